// File: doc/BRIEF.md
# Programmable Sync Pulse Generator

This block produces a periodic sync pulse, one fast-clock cycle wide, inside a 100 MHz clock domain that is phase-aligned to a 10 MHz reference. The reference edge reaches the block as a one-cycle enable (`refTick`) that arrives once every ten fast cycles. The block issues a pulse on every n-th reference tick, so the pulse rate is 10/n MHz. The divisor n is an 8-bit input and may take any value from 1 to 255. The pulse always lines up with a reference tick, so its phase relative to the slow edge is the same for every divisor.

When a new divisor is written, the period already in progress finishes on the old value. The new value is loaded when the next pulse is issued. This means a divisor change never produces a shortened period. An asynchronous restart input passes through a synchronizer, and its rising edge forces a pulse on the next reference tick, with the divider then reloaded. Several generators that share a reference can therefore be brought into phase by raising their restart lines together.

Top module: `syncgen_top`

## Requirements
- R1: `syncPulse` is never high for two fast cycles in a row.
- R2: `syncPulse` is high only in the fast cycle directly after a cycle in which `refTick` was sampled high.
- R3: With a steady divisor n in 1..255, consecutive pulses are exactly n reference ticks apart (10·n fast cycles when ticks come every 10 cycles), and no more than 255 ticks pass between pulses.
- R4: A divisor value of 0 behaves exactly like 1: a pulse follows every reference tick.
- R5: While `rstN` is low, `syncPulse` is low. The first reference tick after reset is released always yields a pulse.
- R6: A divisor change does not shorten or stretch the period in progress. The new value governs the period that starts with the next pulse.
- R7: A rising edge on `restartAsync` that happens at least three fast cycles before a reference tick causes a pulse on that tick. Pulses then continue every n ticks counted from that tick.
- R8: Only rising edges of `restartAsync` act. Holding it high, or lowering it, leaves the pulse train on its regular n-tick period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 MHz fast clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One-cycle enable marking each 10 MHz reference edge |
| divisor | input | DIV_W (8) | Divisor n; 0 is treated as 1 |
| restartAsync | input | 1 | Asynchronous restart request, acts on its rising edge |
| syncPulse | output | 1 | Sync pulse, one fast cycle wide |

## Verification
The pulse for a firing tick becomes visible one fast cycle after the edge that samples `refTick`. The bench therefore samples the output on the falling edge that follows each rising edge, and it expects a pulse exactly when the tick it drove one step earlier should have fired. A divisor change is expected to take effect only after the next pulse, so period measurements start from that pulse. A restart edge needs two synchronizer edges plus one cycle for edge detection, so restart stimulus is always placed at least three fast cycles ahead of the tick that must respond. The expected gap is then checked in whole multiples of ten cycles.

// File: rtl/syncgen_pkg.sv
package syncgen_pkg;
  // strobes from the control side to the divider datapath
  typedef struct packed {
    logic fire;     // issue a pulse and reload the divider
    logic advance;  // reference tick without a pulse: count down
  } divStrobe_t;
endpackage

// File: rtl/syncgen_ctrl.sv
module syncgen_ctrl
  import syncgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  logic       restartAsync,
  input  logic       atTerminal,
  output divStrobe_t strobe
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic restartSeen;
  logic restartPrev;
  logic restartEdge;
  logic restartPend;
  logic armed;

  // restart synchronizer, depth chosen by parameter
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : gSync
    if (i == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (!rstN) syncChain[0] <= 1'b0;
        else       syncChain[0] <= restartAsync;
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (!rstN) syncChain[i] <= 1'b0;
        else       syncChain[i] <= syncChain[i-1];
      end
    end
  end

  assign restartSeen = syncChain[SYNC_STAGES-1];
  assign restartEdge = restartSeen & ~restartPrev;
  assign armed       = restartPend | restartEdge;

  always_comb begin
    strobe.fire    = refTick & (atTerminal | armed);
    strobe.advance = refTick & ~(atTerminal | armed);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      restartPrev <= 1'b0;
      restartPend <= 1'b0;
    end else begin
      restartPrev <= restartSeen;
      if (strobe.fire)      restartPend <= 1'b0;
      else if (restartEdge) restartPend <= 1'b1;
    end
  end
endmodule

// File: rtl/syncgen_datapath.sv
module syncgen_datapath
  import syncgen_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  divStrobe_t       strobe,
  output logic             atTerminal,
  output logic             syncPulse
);
  logic [DIV_W-1:0] ticksLeft;
  logic [DIV_W-1:0] effDiv;

  // zero is mapped to one so the reload never underflows
  assign effDiv     = (divisor == '0) ? DIV_W'(1) : divisor;
  assign atTerminal = (ticksLeft == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ticksLeft <= '0;
      syncPulse <= 1'b0;
    end else begin
      syncPulse <= strobe.fire;
      if (strobe.fire)         ticksLeft <= effDiv - 1'b1;
      else if (strobe.advance) ticksLeft <= ticksLeft - 1'b1;
    end
  end
endmodule

// File: rtl/syncgen_top.sv
module syncgen_top
  import syncgen_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic [DIV_W-1:0] divisor,
  input  logic             restartAsync,
  output logic             syncPulse
);
  divStrobe_t strobe;
  logic atTerminal;

  syncgen_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .refTick(refTick),
    .restartAsync(restartAsync), .atTerminal(atTerminal), .strobe(strobe)
  );

  syncgen_datapath #(.DIV_W(DIV_W)) dp_i (
    .clk(clk), .rstN(rstN), .divisor(divisor), .strobe(strobe),
    .atTerminal(atTerminal), .syncPulse(syncPulse)
  );
endmodule

// File: rtl/syncgen_chk.sv
module syncgen_chk #(
  parameter int DIV_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic refTick,
  input logic syncPulse
);
  localparam int MAX_GAP = (1 << DIV_W) - 1;
  logic [DIV_W:0] ticksSince;
  logic tickSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ticksSince <= '0;
      tickSeen   <= 1'b0;
    end else begin
      if (refTick) tickSeen <= 1'b1;
      if (syncPulse)    ticksSince <= refTick ? (DIV_W+1)'(1) : '0;
      else if (refTick) ticksSince <= ticksSince + 1'b1;
    end
  end

  AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |=> !syncPulse); // R1
  AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !refTick |=> !syncPulse); // R2
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ticksSince <= (DIV_W+1)'(MAX_GAP)); // R3
  AST_FIRST_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (refTick && !tickSeen) |=> syncPulse); // R5
endmodule

bind syncgen_top syncgen_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rstN(rstN), .refTick(refTick), .syncPulse(syncPulse)
);

// File: tb/syncgen_top_tb_top.sv
module syncgen_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {divisor, expected period in fast cycles}
  localparam logic [23:0] VEC_TABLE [NVEC] = '{
    {8'd1, 16'd10}, {8'd2, 16'd20}, {8'd3, 16'd30}, {8'd0, 16'd10},
    {8'd7, 16'd70}, {8'd16, 16'd160}, {8'd255, 16'd2550}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refTick = 1'b0;
  logic [7:0] divisor = 8'd1;
  logic restartAsync = 1'b0;
  logic syncPulse;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int phase = 0;
  logic obs = 1'b0;
  logic lastObs = 1'b0;
  logic prevDriven = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  syncgen_top dut_i (
    .clk(clk), .rstN(rstN), .refTick(refTick), .divisor(divisor),
    .restartAsync(restartAsync), .syncPulse(syncPulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one fast cycle: sample result of the last edge, then drive the next tick
  task automatic step();
    @(negedge clk);
    obs = syncPulse;
    if (obs && rstN) begin
      chk("R2 pulse follows tick", int'(prevDriven), 1);
      chk("R1 pulse one cycle", int'(lastObs), 0);
    end
    lastObs = obs;
    cyc++;
    phase = (phase == 9) ? 0 : phase + 1;
    refTick = (phase == 0);
    prevDriven = refTick;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic waitPulse(input string req, output int at);
    at = -1;
    for (int i = 0; i < 3000; i++) begin
      step();
      if (obs) begin
        at = cyc;
        break;
      end
    end
    if (at < 0) chk(req, 0, 1);
  endtask

  initial begin
    int a, b, c, d, e;
    // R5 reset state
    for (int i = 0; i < 25; i++) begin
      step();
      if (i % 8 == 0) chk("R5 low in reset", int'(obs), 0);
    end
    rstN = 1'b1;
    while (!refTick) step();
    step();
    chk("R5 first tick pulses", int'(obs), 1);

    // R3 / R4 table walk
    for (int v = 0; v < NVEC; v++) begin
      divisor = VEC_TABLE[v][23:16];
      waitPulse("R3 pulse seen", a);
      waitPulse("R3 pulse seen", b);
      waitPulse("R3 pulse seen", c);
      if (VEC_TABLE[v][23:16] == 8'd0) begin
        chk("R4 zero acts as one", b - a, int'(VEC_TABLE[v][15:0]));
        chk("R4 zero acts as one", c - b, int'(VEC_TABLE[v][15:0]));
      end else begin
        chk("R3 period", b - a, int'(VEC_TABLE[v][15:0]));
        chk("R3 period", c - b, int'(VEC_TABLE[v][15:0]));
      end
    end

    // R6 divisor change mid period
    divisor = 8'd5;
    waitPulse("R6 pulse seen", a);
    divisor = 8'd2;
    waitPulse("R6 pulse seen", b);
    chk("R6 old period completes", b - a, 50);
    waitPulse("R6 pulse seen", c);
    chk("R6 new period applies", c - b, 20);

    // R7 / R8 restart
    divisor = 8'd8;
    waitPulse("R7 pulse seen", a);
    waitPulse("R7 pulse seen", b);
    chk("R7 baseline period", b - a, 80);
    restartAsync = 1'b1;
    waitPulse("R7 pulse seen", c);
    chk("R7 restart pulses next tick", c - b, 10);
    waitPulse("R8 pulse seen", d);
    chk("R8 held high no effect", d - c, 80);
    restartAsync = 1'b0;
    waitPulse("R8 pulse seen", e);
    chk("R8 falling edge no effect", e - d, 80);
    run(35);
    restartAsync = 1'b1;
    waitPulse("R7 pulse seen", a);
    chk("R7 mid period restart", a - e, 40);
    waitPulse("R7 pulse seen", b);
    chk("R7 period resumes", b - a, 80);
    restartAsync = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule